// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Unit

This block keeps one 32-bit control/status word for each of `NUM_CH` DMA channels, where `NUM_CH` is a parameter of up to 32. It also forms the per-channel interrupt summary and drives the single interrupt line.

Software writes a channel's word over a simple word-aligned register port. Each field of that word follows its own write rule:
- Event flags are cleared by writing 1 to them.
- Control fields are loaded directly from the write data.
- The compare-status flag is changed through a separate clear bit and a separate set bit.

The transfer engine reports bus errors, descriptor starts, transfer ends and halts on one-cycle strobe inputs. The request mapper supplies a level for each channel. A rising edge on that level marks a request-after-start event, and a falling edge marks end-of-receive.

Every channel has five interrupt causes:
- stopped, gated by its enable bit;
- end-of-receive, gated by its enable bit;
- request-after-start, gated by its enable bit;
- start, which has no enable;
- end, which has no enable.

A channel's bit in the summary register is the OR of its five causes. The interrupt output is high whenever any summary bit is set. The run bit of each channel is exported so that the transfer engine can see it.

Top module: `dma_status_irq`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stopped flag, bit 3, set), the summary register reads 0 and `irq` is low.
- R2: In a write to channel n (byte address 4*n), a 1 in bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. A 0 in any of these bits leaves the flag unchanged.
- R3: A write loads bits 31..26 and bit 23 directly from the write data. Bits 22, 24 and 25 are never stored and always read back as 0.
- R4: Writing 1 to bit 24 clears compare status (bit 10), and writing 1 to bit 25 sets it. When both are 1 in the same write, the set takes effect.
- R5: A write with run (bit 31) = 1 clears the stopped flag. A write with run = 0 and mask-run (bit 22) = 0 sets it. A write with run = 0 and mask-run = 1 leaves it unchanged.
- R6: A halt strobe on `ev_halt[n]` sets the stopped flag of channel n and clears its run bit, and `chan_run[n]` then goes low.
- R7: The strobes `ev_buserr[n]`, `ev_start[n]` and `ev_end[n]` set bits 0, 1 and 2 respectively of channel n.
- R8: A rising edge of `req_active[n]` sets bit 4 (request-after-start). A falling edge sets bit 9 and clears bit 4.
- R9: A read of a channel word returns bit 8 set exactly while that channel's `req_active` is high, in the same cycle the level changes.
- R10: The stopped, end-of-receive and request-after-start flags count as interrupt causes only while bit 29, bit 28 and bit 23 respectively are set. The start and end flags count whenever they are set. The bus error flag never raises an interrupt.
- R11: The summary register at byte address 0x80 has bit n set when channel n has any active cause, and `irq` is high when any summary bit is set.
- R12: Writes to the summary register, writes with `bus_addr[1:0]` not equal to 0, and writes to unmapped words change no state. Reads of unmapped or misaligned addresses return 0.
- R13: When a strobe sets a flag in the same cycle that a write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ev_buserr | input | NUM_CH | Bus error strobe per channel |
| ev_start | input | NUM_CH | Descriptor start strobe per channel |
| ev_end | input | NUM_CH | Transfer end strobe per channel |
| ev_halt | input | NUM_CH | Channel halted strobe per channel |
| req_active | input | NUM_CH | Request level per channel from the mapper |
| chan_run | output | NUM_CH | Stored run bit of each channel |
| irq | output | 1 | OR of all enabled interrupt causes |

## Verification
On every cycle, the assertions check the following:
- the run and mask-run rules for the stopped flag;
- halt handling;
- the compare set bit;
- a request rising edge leading to its flag;
- a strobe winning over a same-cycle clear;
- the link between each channel's start/end causes and the shared interrupt line.

Some behaviour can only be shown by the bench's directed scenarios:
- the exact read-back values of each word after mixed writes;
- the masking of non-stored bits;
- the live request-pending bit;
- the gating of each enable-controlled cause;
- the summary contents across channels;
- writes to the summary, misaligned and unmapped addresses being ignored.

// File: rtl/dma_stat_pkg.sv
// Package: bit positions, write masks and the cause record shared by the
// channel status unit. Assumes 32-bit channel words.
package dma_stat_pkg;
    localparam int B_BUSERR  = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASEN   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EOREN   = 28;
    localparam int B_STOPEN  = 29;
    localparam int B_RUN     = 31;

    // Status flags that survive a write (request pending is never stored).
    localparam logic [31:0] KEEP_MASK  = 32'h0000_061F;
    // Flags cleared by writing one.
    localparam logic [31:0] W1C_MASK   = 32'h0000_0207;
    // Control fields loaded directly from write data.
    localparam logic [31:0] LOAD_MASK  = 32'hFC80_0000;
    localparam logic [31:0] RESET_WORD = 32'h0000_0008;

    typedef struct packed {
        logic stop;
        logic eor;
        logic ras;
        logic start;
        logic fin;
    } cause_t;
endpackage

// File: rtl/dma_chan_status.sv
// Module: one channel's control/status word. Applies the bus write rules
// first and then the engine/mapper events, so events win over same-cycle
// clears. Assumes wr_en is already decoded for this channel and aligned.
module dma_chan_status
    import dma_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        ev_buserr,
    input  logic        ev_start,
    input  logic        ev_end,
    input  logic        ev_halt,
    input  logic        req,
    output logic [31:0] stat,
    output cause_t      cause
);
    logic [31:0] nxt;
    logic        req_q;

    // Next-state: write semantics, then event sets.
    always_comb begin
        nxt = stat;
        if (wr_en) begin
            nxt = (stat & KEEP_MASK & ~(wdata & W1C_MASK)) | (wdata & LOAD_MASK);
            if (wdata[B_RUN])
                nxt[B_STOP] = 1'b0;
            else if (!wdata[B_MASKRUN])
                nxt[B_STOP] = 1'b1;
            if (wdata[B_CMPCLR])
                nxt[B_CMP] = 1'b0;
            if (wdata[B_CMPSET])
                nxt[B_CMP] = 1'b1;
        end
        if (ev_buserr) nxt[B_BUSERR] = 1'b1;
        if (ev_start)  nxt[B_START]  = 1'b1;
        if (ev_end)    nxt[B_END]    = 1'b1;
        if (ev_halt) begin
            nxt[B_STOP] = 1'b1;
            nxt[B_RUN]  = 1'b0;
        end
        if (req && !req_q)
            nxt[B_RAS] = 1'b1;
        if (!req && req_q) begin
            nxt[B_RAS] = 1'b0;
            nxt[B_EOR] = 1'b1;
        end
    end

    // State register and request edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= RESET_WORD;
            req_q <= 1'b0;
        end else begin
            stat  <= nxt;
            req_q <= req;
        end
    end

    // Cause gating by enable bits.
    always_comb begin
        cause.stop  = stat[B_STOP] & stat[B_STOPEN];
        cause.eor   = stat[B_EOR]  & stat[B_EOREN];
        cause.ras   = stat[B_RAS]  & stat[B_RASEN];
        cause.start = stat[B_START];
        cause.fin   = stat[B_END];
    end

    // R5
    run_clears_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_RUN] && !ev_halt |=> !stat[B_STOP]);
    // R5
    idle_sets_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wdata[B_RUN] && !wdata[B_MASKRUN] |=> stat[B_STOP]);
    // R4
    cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_CMPSET] |=> stat[B_CMP]);
    // R6
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> stat[B_STOP] && !stat[B_RUN]);
    // R8
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |=> stat[B_RAS]);
    // R13
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end |=> stat[B_END]);
endmodule

// File: rtl/dma_irq_combine.sv
// Module: folds each channel's gated causes into a summary bit and the
// shared interrupt line. Purely combinational; assumes causes are registered.
module dma_irq_combine
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  cause_t            cause_in [NUM_CH],
    output logic [NUM_CH-1:0] summary,
    output logic              irq
);
    // Per-channel OR of the five causes, then global OR.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            summary[i] = |cause_in[i];
        irq = |summary;
    end
endmodule

// File: rtl/dma_status_irq.sv
// Module: top of the channel status/interrupt unit. Decodes word-aligned
// register accesses, instantiates one status word per channel and the
// interrupt combiner. Assumes NUM_CH <= 32 and ADDR_W wide enough for SUM_WORD.
module dma_status_irq
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int ADDR_W   = 8,
    parameter int SUM_WORD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_halt,
    input  logic [NUM_CH-1:0] req_active,
    output logic [NUM_CH-1:0] chan_run,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] SUM_IDX = WORD_W'(SUM_WORD);

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic [31:0]       stat_arr [NUM_CH];
    cause_t            causes   [NUM_CH];
    logic [NUM_CH-1:0] summary;
    logic [NUM_CH-1:0] start_vec;
    logic [NUM_CH-1:0] end_vec;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // One status word per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_chan_status u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && aligned && (word == WORD_W'(g))),
            .wdata     (bus_wdata),
            .ev_buserr (ev_buserr[g]),
            .ev_start  (ev_start[g]),
            .ev_end    (ev_end[g]),
            .ev_halt   (ev_halt[g]),
            .req       (req_active[g]),
            .stat      (stat_arr[g]),
            .cause     (causes[g])
        );
        assign chan_run[g]  = stat_arr[g][B_RUN];
        assign start_vec[g] = causes[g].start;
        assign end_vec[g]   = causes[g].fin;
    end

    dma_irq_combine #(.NUM_CH(NUM_CH)) u_comb (
        .cause_in (causes),
        .summary  (summary),
        .irq      (irq)
    );

    // Read mux: channel word with live request pending, or summary.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_CH; i++)
                if (word == WORD_W'(i))
                    bus_rdata = stat_arr[i] | {23'b0, req_active[i], 8'b0};
            if (word == SUM_IDX)
                bus_rdata = 32'(summary);
        end
    end

    // R11
    irq_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|end_vec) |-> irq);
    // R10
    irq_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> !(|start_vec));
endmodule

// File: tb/dma_status_irq_test.sv
module dma_status_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam logic [7:0] SUM_A = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] ev_buserr = '0, ev_start = '0, ev_end = '0, ev_halt = '0;
    logic [NCH-1:0] req_active = '0;
    logic [NCH-1:0] chan_run;
    logic irq;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_status_irq #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_buserr(ev_buserr),
        .ev_start(ev_start), .ev_end(ev_end), .ev_halt(ev_halt),
        .req_active(req_active), .chan_run(chan_run), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic test_reset();
        for (int i = 0; i < NCH; i++) rd_chk("R1 chan word", 8'(i*4), 32'h8);
        rd_chk("R1 summary", SUM_A, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_run_rules();
        wr(8'h04, 32'h8000_0000);
        rd_chk("R5 run clears stop", 8'h04, 32'h8000_0000);
        check("R5 chan_run", {31'b0, chan_run[1]}, 32'h1);
        wr(8'h04, 32'h0040_0000);
        rd_chk("R5 mask-run keeps stop", 8'h04, 32'h0);
        wr(8'h04, 32'h0);
        rd_chk("R5 idle sets stop", 8'h04, 32'h8);
    endtask

    task automatic test_ctrl_cmp();
        wr(8'h08, 32'hFC80_0000);
        rd_chk("R3 direct load", 8'h08, 32'hFC80_0000);
        wr(8'h08, 32'h0340_0000);
        rd_chk("R4 set cmp, R3 22/24/25 not stored", 8'h08, 32'h0000_0400);
        wr(8'h08, 32'h0100_0000);
        rd_chk("R4 clear cmp", 8'h08, 32'h8);
        wr(8'h08, 32'h0300_0000);
        rd_chk("R4 set wins", 8'h08, 32'h408);
    endtask

    task automatic test_events();
        @(negedge clk); ev_start[3] = 1; ev_end[3] = 1; ev_buserr[3] = 1;
        @(negedge clk); ev_start = '0; ev_end = '0; ev_buserr = '0;
        rd_chk("R7 flags set", 8'h0C, 32'hF);
        rd_chk("R11 summary start/end", SUM_A, 32'h08);
        check("R11 irq", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h2);
        rd_chk("R2 w1c start", 8'h0C, 32'hD);
        wr(8'h0C, 32'h5);
        rd_chk("R2 w1c end/buserr", 8'h0C, 32'h8);
        check("R2 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk); ev_buserr[3] = 1;
        @(negedge clk); ev_buserr = '0;
        rd_chk("R10 buserr flag", 8'h0C, 32'h9);
        check("R10 buserr no irq", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h1);
    endtask

    task automatic test_halt();
        wr(8'h10, 32'h8000_0000);
        @(negedge clk); ev_halt[4] = 1;
        @(negedge clk); ev_halt = '0;
        rd_chk("R6 halt", 8'h10, 32'h8);
        check("R6 chan_run low", {31'b0, chan_run[4]}, 32'h0);
    endtask

    task automatic test_request();
        @(negedge clk); req_active[5] = 1;
        bus_addr = 8'h14;
        #1 check("R9 live pending", bus_rdata, 32'h108);
        rd_chk("R8 rise sets ras", 8'h14, 32'h118);
        rd_chk("R10 ras gated off", SUM_A, 32'h0);
        wr(8'h14, 32'h00C0_0000);
        rd_chk("R3 ras enable", 8'h14, 32'h0080_0118);
        rd_chk("R10 ras enabled", SUM_A, 32'h20);
        @(negedge clk); req_active[5] = 0;
        rd_chk("R8 fall sets eor", 8'h14, 32'h0080_0208);
        rd_chk("R10 eor gated off", SUM_A, 32'h0);
        wr(8'h14, 32'h1040_0000);
        rd_chk("R10 eor enabled", SUM_A, 32'h20);
        wr(8'h14, 32'h1040_0200);
        rd_chk("R2 w1c eor", 8'h14, 32'h1000_0008);
    endtask

    task automatic test_stop_and_ignore();
        rd_chk("R10 stop gated off", SUM_A, 32'h0);
        wr(8'h18, 32'h2040_0000);
        rd_chk("R10 stop enabled", SUM_A, 32'h40);
        wr(SUM_A, 32'hFFFF_FFFF);
        rd_chk("R12 summary write ignored", SUM_A, 32'h40);
        rd_chk("R12 ch0 untouched", 8'h00, 32'h8);
        wr(8'h19, 32'h8000_0000);
        rd_chk("R12 misaligned write ignored", 8'h18, 32'h2000_0008);
        rd_chk("R12 misaligned read", 8'h19, 32'h0);
        rd_chk("R12 unmapped read", 8'h40, 32'h0);
        wr(8'h18, 32'hA000_0000);
        rd_chk("R5 run clears stop cause", SUM_A, 32'h0);
        check("R11 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_collision();
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h0040_0004; ev_end[7] = 1;
        @(negedge clk);
        bus_wr = 0; ev_end = '0;
        rd_chk("R13 event beats clear", 8'h1C, 32'hC);
        rd_chk("R11 summary ch7", SUM_A, 32'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_run_rules();
        test_ctrl_cmp();
        test_events();
        test_halt();
        test_request();
        test_stop_and_ignore();
        test_collision();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule